// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block is the front end of an SMBus host controller. Software programs a small set of byte-wide registers: a slave address with its read/write flag, a command code and up to two data bytes. A write to the control register with the start bit set and a transaction-type code then launches exactly one SMBus transaction. The supported types are quick, byte, byte-data and word-data.

The sequencer converts the transaction into a list of primitive operations for a bit-level bus engine: START, SEND byte, RECV byte and STOP. It issues them one at a time and waits for each to complete. It collects received bytes into the data registers. Outcomes are reported in a status register whose flag bits are cleared by writing one. Software can abort a running transaction with a kill bit.

Top module: `smbus_host_seq`

## Requirements
- R1: After reset every register reads 0x00 and no engine request is issued.
- R2: Writing control (offset 2) with bit 6 set is accepted only while status bits 4:0 are all zero. Status bit 0 (busy) reads 1 from the cycle after the accepted write, and control bit 6 always reads 0. A start written while any of status bits 4:0 is set causes no bus activity.
- R3: The type code sits in control bits 4:2, and the engine op codes are START=0, SEND=1, RECV=2 and STOP=3. Type 0 (quick) issues START, then SEND of the address register byte unchanged, then STOP. It ends with status bit 1 (done) set and busy clear.
- R4: Type 1 (byte) writes issue START, SEND address, SEND command, STOP. Byte reads issue START, SEND address, then RECV with the last flag set, then STOP. The received byte goes into data0 (offset 5).
- R5: Type 2 (byte-data) writes issue START, SEND address with bit 0 forced to 0, SEND command, SEND data0, STOP. Byte-data reads issue START, SEND address with bit 0 forced to 0, SEND command, a repeated START, SEND address with bit 0 forced to 1, a last RECV into data0, then STOP.
- R6: Type 3 (word-data) writes send data0 and then data1 (offset 6) after the command. Word-data reads perform a RECV without the last flag into data0, then a last RECV into data1.
- R7: A SEND that the slave does not acknowledge sets status bit 2 (device error). A STOP is still issued afterwards. The transaction ends with busy clear and done left at 0.
- R8: An engine completion that reports lost arbitration or a collision sets status bit 3 (bus error). The transaction ends at once, with no further engine request.
- R9: Setting control bit 1 (kill) while busy produces a one-cycle abort pulse toward the engine. It also sets status bit 4 (failed) and clears busy, and no further engine request follows.
- R10: A start with a type code of 4 to 7 sets failed and clears busy without issuing any engine request.
- R11: Writing the status register clears each of bits 4:1 whose written bit is 1 and leaves every other bit unchanged. Busy cannot be written.
- R12: While busy, writes to command (offset 3), address (offset 4), data0 and data1 are ignored. The bytes the transaction sends are the values held at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register offset for read and write |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| eng_req | output | 1 | One-cycle request to the bus engine |
| eng_op | output | 2 | Requested operation: 0 START, 1 SEND, 2 RECV, 3 STOP |
| eng_txbyte | output | 8 | Byte to send on a SEND |
| eng_last | output | 1 | On a RECV: answer the byte with NACK |
| eng_abort | output | 1 | One-cycle pulse: drop the current operation |
| eng_done | input | 1 | Engine completed the requested operation |
| eng_nack | input | 1 | With eng_done: the sent byte was not acknowledged |
| eng_lost | input | 1 | With eng_done: arbitration lost or collision |
| eng_rxbyte | input | 8 | With eng_done on a RECV: received byte |

## Verification
Each of the four transaction types is run in both directions with random addresses, commands and data. A modelled engine uses random completion latency, so the recorded operation lists tell apart the write and read shapes, the forced address bit of the combined formats and the placement of the repeated START. Read transactions return random bytes, which separates data0 from data1 and the acknowledged RECV from the last one. Injected NACKs on a randomly chosen SEND and collisions on a random operation separate the STOP-after-error path from the immediate-end path. Directed cases cover kill mid-operation, the unsupported type codes, a start refused by pending status, selective write-one-to-clear, and register writes made during a long operation.

// File: rtl/smbh_pkg.sv
// Shared types for the SMBus host sequencer.
// Holds the engine op codes, the byte-source selector and the step planner
// that maps (type, direction, step index) to one engine operation.
package smbh_pkg;

    localparam int BYTE_W = 8;
    localparam int STEP_W = 3;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_ADDR,
        SRC_ADDR_WR,
        SRC_ADDR_RD,
        SRC_CMD,
        SRC_D0,
        SRC_D1
    } byte_src_e;

    typedef struct packed {
        bus_op_e   op;
        byte_src_e src;
        logic      to_d1;
        logic      last;
    } step_t;

    localparam logic [2:0] KIND_QUICK = 3'd0;
    localparam logic [2:0] KIND_BYTE  = 3'd1;
    localparam logic [2:0] KIND_BDATA = 3'd2;
    localparam logic [2:0] KIND_WORD  = 3'd3;

    function automatic step_t mk_step(bus_op_e op, byte_src_e src, logic to_d1, logic last);
        step_t s;
        s.op = op;
        s.src = src;
        s.to_d1 = to_d1;
        s.last = last;
        return s;
    endfunction

    // Returns the engine operation for a given step; anything past the end is STOP.
    function automatic step_t plan_step(logic [2:0] kind, logic rd, logic [STEP_W-1:0] idx);
        step_t s;
        s = mk_step(OP_STOP, SRC_NONE, 1'b0, 1'b0);
        if (idx == 0) begin
            s = mk_step(OP_START, SRC_NONE, 1'b0, 1'b0);
        end else begin
            case (kind)
                KIND_QUICK: begin
                    if (idx == 1) s = mk_step(OP_SEND, SRC_ADDR, 1'b0, 1'b0);
                end
                KIND_BYTE: begin
                    if (idx == 1) s = mk_step(OP_SEND, SRC_ADDR, 1'b0, 1'b0);
                    else if (idx == 2) s = rd ? mk_step(OP_RECV, SRC_NONE, 1'b0, 1'b1)
                                              : mk_step(OP_SEND, SRC_CMD, 1'b0, 1'b0);
                end
                KIND_BDATA, KIND_WORD: begin
                    if (idx == 1) s = mk_step(OP_SEND, SRC_ADDR_WR, 1'b0, 1'b0);
                    else if (idx == 2) s = mk_step(OP_SEND, SRC_CMD, 1'b0, 1'b0);
                    else if (rd) begin
                        if (idx == 3) s = mk_step(OP_START, SRC_NONE, 1'b0, 1'b0);
                        else if (idx == 4) s = mk_step(OP_SEND, SRC_ADDR_RD, 1'b0, 1'b0);
                        else if (idx == 5) s = mk_step(OP_RECV, SRC_NONE, 1'b0, kind == KIND_BDATA);
                        else if (idx == 6 && kind == KIND_WORD)
                            s = mk_step(OP_RECV, SRC_NONE, 1'b1, 1'b1);
                    end else begin
                        if (idx == 3) s = mk_step(OP_SEND, SRC_D0, 1'b0, 1'b0);
                        else if (idx == 4 && kind == KIND_WORD)
                            s = mk_step(OP_SEND, SRC_D1, 1'b0, 1'b0);
                    end
                end
                default: s = mk_step(OP_STOP, SRC_NONE, 1'b0, 1'b0);
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/smbh_regs.sv
// Register file and status logic of the SMBus host sequencer.
// Decodes byte-wide register writes, accepts start only when status is clear,
// holds write-one-to-clear status flags and freezes transfer registers while busy.
// Assumes the sequencer raises at most one finish pulse per cycle.
module smbh_regs
    import smbh_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              fin_ok,
    input  logic              fin_dev,
    input  logic              fin_bus,
    input  logic              fin_fail,
    input  logic              rx_we,
    input  logic              rx_to_d1,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              start_acc,
    output logic [2:0]        kind_q,
    output logic              kill_q,
    output logic [BYTE_W-1:0] addr_q,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] d0_q,
    output logic [BYTE_W-1:0] d1_q
);

    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_CMD  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] OFS_ADDR = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_D0   = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] OFS_D1   = ADDR_W'(6);

    logic busy_q, done_q, dev_q, bus_q, fail_q, pec_q;
    logic any_fin, stat_we, ctrl_we, free_we;

    assign any_fin = fin_ok | fin_dev | fin_bus | fin_fail;
    assign stat_we = reg_we && (reg_addr == OFS_STAT);
    assign ctrl_we = reg_we && (reg_addr == OFS_CTRL);
    assign free_we = reg_we && !busy_q;
    assign start_acc = ctrl_we && reg_wdata[6] &&
                       !(busy_q | done_q | dev_q | bus_q | fail_q);

    // Status flags: finish events set, written ones clear, busy follows start/finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            dev_q  <= 1'b0;
            bus_q  <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            if (start_acc)    busy_q <= 1'b1;
            else if (any_fin) busy_q <= 1'b0;
            done_q <= fin_ok   | (done_q & ~(stat_we & reg_wdata[1]));
            dev_q  <= fin_dev  | (dev_q  & ~(stat_we & reg_wdata[2]));
            bus_q  <= fin_bus  | (bus_q  & ~(stat_we & reg_wdata[3]));
            fail_q <= fin_fail | (fail_q & ~(stat_we & reg_wdata[4]));
        end
    end

    // Control fields: kill always writable, type and PEC enable only when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= 3'd0;
            kill_q <= 1'b0;
            pec_q  <= 1'b0;
        end else if (ctrl_we) begin
            kill_q <= reg_wdata[1];
            if (!busy_q) begin
                kind_q <= reg_wdata[4:2];
                pec_q  <= reg_wdata[7];
            end
        end
    end

    // Transfer registers: software writes when idle, received bytes when busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
            d0_q   <= '0;
            d1_q   <= '0;
        end else begin
            if (free_we && reg_addr == OFS_ADDR) addr_q <= reg_wdata;
            if (free_we && reg_addr == OFS_CMD)  cmd_q  <= reg_wdata;
            if (rx_we && !rx_to_d1)              d0_q   <= rx_byte;
            else if (free_we && reg_addr == OFS_D0) d0_q <= reg_wdata;
            if (rx_we && rx_to_d1)               d1_q   <= rx_byte;
            else if (free_we && reg_addr == OFS_D1) d1_q <= reg_wdata;
        end
    end

    // Read mux; the start bit is a pulse and never reads back.
    always_comb begin
        case (reg_addr)
            OFS_STAT: reg_rdata = {3'b000, fail_q, bus_q, dev_q, done_q, busy_q};
            OFS_CTRL: reg_rdata = {pec_q, 2'b00, kind_q, kill_q, 1'b0};
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_ADDR: reg_rdata = addr_q;
            OFS_D0:   reg_rdata = d0_q;
            OFS_D1:   reg_rdata = d1_q;
            default:  reg_rdata = '0;
        endcase
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> busy_q);

    assert_done_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> !(dev_q || bus_q || fail_q));

    assert_w1c_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && reg_wdata[1] && !fin_ok) |=> !done_q);

    assert_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ($stable(addr_q) && $stable(cmd_q)));

endmodule

// File: rtl/smbh_seq.sv
// Transaction sequencer of the SMBus host.
// Walks the step plan for the latched type, issues one engine request per step,
// routes received bytes, and ends on STOP completion, collision, kill or bad type.
// Assumes addr/kind are frozen by the register file while a transaction runs.
module smbh_seq
    import smbh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_acc,
    input  logic [2:0]        kind_q,
    input  logic              kill_q,
    input  logic [BYTE_W-1:0] addr_q,
    input  logic [BYTE_W-1:0] cmd_q,
    input  logic [BYTE_W-1:0] d0_q,
    input  logic [BYTE_W-1:0] d1_q,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic              eng_lost,
    input  logic [BYTE_W-1:0] eng_rxbyte,
    output logic              eng_req,
    output bus_op_e           eng_op,
    output logic [BYTE_W-1:0] eng_txbyte,
    output logic              eng_last,
    output logic              eng_abort,
    output logic              fin_ok,
    output logic              fin_dev,
    output logic              fin_bus,
    output logic              fin_fail,
    output logic              rx_we,
    output logic              rx_to_d1,
    output logic [BYTE_W-1:0] rx_byte
);

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} seq_state_e;

    seq_state_e        state_q;
    logic [STEP_W-1:0] idx_q;
    logic              stopping_q, dev_pend_q;
    step_t             cur;
    logic              supported;

    assign supported = (kind_q[2] == 1'b0);
    assign cur = stopping_q ? mk_step(OP_STOP, SRC_NONE, 1'b0, 1'b0)
                            : plan_step(kind_q, addr_q[0], idx_q);

    // Engine-facing fields of the current step.
    always_comb begin
        eng_op   = cur.op;
        eng_last = cur.last;
        rx_to_d1 = cur.to_d1;
        rx_byte  = eng_rxbyte;
        case (cur.src)
            SRC_ADDR:    eng_txbyte = addr_q;
            SRC_ADDR_WR: eng_txbyte = {addr_q[BYTE_W-1:1], 1'b0};
            SRC_ADDR_RD: eng_txbyte = {addr_q[BYTE_W-1:1], 1'b1};
            SRC_CMD:     eng_txbyte = cmd_q;
            SRC_D0:      eng_txbyte = d0_q;
            SRC_D1:      eng_txbyte = d1_q;
            default:     eng_txbyte = '0;
        endcase
    end

    // Per-cycle requests and finish events.
    always_comb begin
        eng_req   = 1'b0;
        eng_abort = 1'b0;
        fin_ok    = 1'b0;
        fin_dev   = 1'b0;
        fin_bus   = 1'b0;
        fin_fail  = 1'b0;
        rx_we     = 1'b0;
        case (state_q)
            ST_ISSUE: begin
                if (kill_q) begin
                    eng_abort = 1'b1;
                    fin_fail  = 1'b1;
                end else if (!supported) begin
                    fin_fail = 1'b1;
                end else begin
                    eng_req = 1'b1;
                end
            end
            ST_WAIT: begin
                if (kill_q) begin
                    eng_abort = 1'b1;
                    fin_fail  = 1'b1;
                end else if (eng_done) begin
                    if (eng_lost) fin_bus = 1'b1;
                    else if (cur.op == OP_STOP) begin
                        fin_ok  = !dev_pend_q;
                        fin_dev = dev_pend_q;
                    end else if (cur.op == OP_RECV) begin
                        rx_we = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // Step walker: advance on completion, divert to STOP after a NACK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_q      <= '0;
            stopping_q <= 1'b0;
            dev_pend_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_acc) begin
                        state_q    <= ST_ISSUE;
                        idx_q      <= '0;
                        stopping_q <= 1'b0;
                        dev_pend_q <= 1'b0;
                    end
                end
                ST_ISSUE: begin
                    if (kill_q || !supported) state_q <= ST_IDLE;
                    else                      state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (kill_q) begin
                        state_q <= ST_IDLE;
                    end else if (eng_done) begin
                        if (eng_lost || cur.op == OP_STOP) begin
                            state_q <= ST_IDLE;
                        end else if (cur.op == OP_SEND && eng_nack) begin
                            stopping_q <= 1'b1;
                            dev_pend_q <= 1'b1;
                            state_q    <= ST_ISSUE;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);

    assert_lost_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && eng_done && eng_lost && !kill_q) |=> !eng_req);

    assert_abort_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> (!eng_req && state_q == ST_IDLE));

endmodule

// File: rtl/smbus_host_seq.sv
// Top of the SMBus host transaction sequencer.
// Joins the register file to the step sequencer and exposes the register port
// and the simplified bus-engine handshake.
module smbus_host_seq
    import smbh_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [7:0]        eng_txbyte,
    output logic              eng_last,
    output logic              eng_abort,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic              eng_lost,
    input  logic [7:0]        eng_rxbyte
);

    logic              start_acc, kill_q;
    logic [2:0]        kind_q;
    logic [BYTE_W-1:0] addr_q, cmd_q, d0_q, d1_q, rx_byte;
    logic              fin_ok, fin_dev, fin_bus, fin_fail, rx_we, rx_to_d1;
    bus_op_e           op_e;

    assign eng_op = op_e;

    smbh_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fin_ok(fin_ok), .fin_dev(fin_dev), .fin_bus(fin_bus), .fin_fail(fin_fail),
        .rx_we(rx_we), .rx_to_d1(rx_to_d1), .rx_byte(rx_byte),
        .start_acc(start_acc), .kind_q(kind_q), .kill_q(kill_q),
        .addr_q(addr_q), .cmd_q(cmd_q), .d0_q(d0_q), .d1_q(d1_q)
    );

    smbh_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_acc(start_acc), .kind_q(kind_q), .kill_q(kill_q),
        .addr_q(addr_q), .cmd_q(cmd_q), .d0_q(d0_q), .d1_q(d1_q),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_lost(eng_lost), .eng_rxbyte(eng_rxbyte),
        .eng_req(eng_req), .eng_op(op_e), .eng_txbyte(eng_txbyte), .eng_last(eng_last),
        .eng_abort(eng_abort),
        .fin_ok(fin_ok), .fin_dev(fin_dev), .fin_bus(fin_bus), .fin_fail(fin_fail),
        .rx_we(rx_we), .rx_to_d1(rx_to_d1), .rx_byte(rx_byte)
    );

endmodule

// File: tb/tb_smbus_host_seq.sv
`timescale 1ns/1ps
module tb_smbus_host_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       eng_req, eng_last, eng_abort;
    logic [1:0] eng_op;
    logic [7:0] eng_txbyte;
    logic       eng_done = 1'b0, eng_nack = 1'b0, eng_lost = 1'b0;
    logic [7:0] eng_rxbyte = '0;

    smbus_host_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_req(eng_req), .eng_op(eng_op), .eng_txbyte(eng_txbyte),
        .eng_last(eng_last), .eng_abort(eng_abort),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_lost(eng_lost),
        .eng_rxbyte(eng_rxbyte)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- engine model ----------------
    int log_op[32], log_byte[32], log_last[32];
    int n_log = 0, rx_vals[4], rx_cnt = 0;
    int inj_nack = -1, inj_lost = -1, lat_cfg = 0, n_abort = 0;
    bit pend = 0;
    int cnt = 0, pend_idx = 0, pend_op = 0;

    always @(negedge clk) begin
        eng_done = 1'b0;
        eng_nack = 1'b0;
        eng_lost = 1'b0;
        if (!rst_n) pend = 0;
        else begin
            if (eng_abort) begin
                n_abort++;
                pend = 0;
            end else if (pend) begin
                cnt--;
                if (cnt == 0) begin
                    pend = 0;
                    eng_done = 1'b1;
                    eng_nack = (pend_idx == inj_nack);
                    eng_lost = (pend_idx == inj_lost);
                    if (pend_op == 2) begin
                        eng_rxbyte = 8'(rx_vals[rx_cnt % 4]);
                        rx_cnt++;
                    end
                end
            end
            if (eng_req && n_log < 32) begin
                log_op[n_log] = eng_op;
                log_byte[n_log] = eng_txbyte;
                log_last[n_log] = eng_last;
                pend = 1;
                pend_idx = n_log;
                pend_op = eng_op;
                cnt = (lat_cfg > 0) ? lat_cfg : int'($urandom_range(1, 3));
                n_log++;
            end
        end
    end

    // ---------------- register access ----------------
    task automatic reg_write(int a, int d);
        @(negedge clk);
        reg_addr = 4'(a);
        reg_wdata = 8'(d);
        reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(int a, output int v);
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        v = reg_rdata;
    endtask

    // ---------------- expected model ----------------
    int x_kind, x_rd, x_areg, x_cmd, x_d0, x_d1, x_err, x_stat;
    int exp_op[16], exp_byte[16], exp_last[16], n_exp;

    function automatic void push(int op, int b, int l);
        exp_op[n_exp] = op;
        exp_byte[n_exp] = b;
        exp_last[n_exp] = l;
        n_exp++;
    endfunction

    function automatic void build_exp();
        int aw, ar;
        aw = x_areg & 8'hFE;
        ar = x_areg | 1;
        n_exp = 0;
        push(0, 0, 0);
        case (x_kind)
            0: push(1, x_areg, 0);
            1: begin
                push(1, x_areg, 0);
                if (x_rd != 0) push(2, 0, 1); else push(1, x_cmd, 0);
            end
            2, 3: begin
                push(1, aw, 0);
                push(1, x_cmd, 0);
                if (x_rd != 0) begin
                    push(0, 0, 0);
                    push(1, ar, 0);
                    if (x_kind == 2) push(2, 0, 1);
                    else begin
                        push(2, 0, 0);
                        push(2, 0, 1);
                    end
                end else begin
                    push(1, x_d0, 0);
                    if (x_kind == 3) push(1, x_d1, 0);
                end
            end
            default: ;
        endcase
        push(3, 0, 0);
    endfunction

    task automatic start_xact(int k, int r, int a7, int c, int v0, int v1, int err);
        int v, pick, nsend;
        x_kind = k; x_rd = r; x_areg = ((a7 & 8'h7F) << 1) | (r & 1);
        x_cmd = c & 8'hFF; x_d0 = v0 & 8'hFF; x_d1 = v1 & 8'hFF; x_err = err;
        reg_write(4, x_areg);
        reg_write(3, x_cmd);
        reg_write(5, x_d0);
        reg_write(6, x_d1);
        build_exp();
        inj_nack = -1;
        inj_lost = -1;
        x_stat = 8'h02;
        if (err == 1) begin
            nsend = 0;
            for (int i = 0; i < n_exp; i++) if (exp_op[i] == 1) nsend++;
            pick = $urandom_range(0, nsend - 1);
            for (int i = 0; i < n_exp; i++) begin
                if (exp_op[i] == 1) begin
                    if (pick == 0 && inj_nack < 0) inj_nack = i;
                    pick--;
                end
            end
            n_exp = inj_nack + 1;
            push(3, 0, 0);
            x_stat = 8'h04;
        end else if (err == 2) begin
            inj_lost = $urandom_range(0, n_exp - 1);
            n_exp = inj_lost + 1;
            x_stat = 8'h08;
        end
        for (int i = 0; i < 4; i++) rx_vals[i] = $urandom_range(0, 255);
        rx_cnt = 0;
        n_log = 0;
        reg_write(2, 8'h40 | (k << 2));
        reg_addr = 4'd0;
        #1;
        v = reg_rdata;
        chk(v[0] == 1'b1, "R2 busy after start", v, v | 1);
        reg_addr = 4'd2;
        #1;
        v = reg_rdata;
        chk(v[6] == 1'b0, "R2 start bit reads zero", v, v & 8'hBF);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            reg_addr = 4'd0;
            #1;
            if (reg_rdata[0] == 1'b0) break;
        end
    endtask

    task automatic finish_xact(string tag);
        int v, bad;
        wait_idle();
        bad = -1;
        if (n_log != n_exp) bad = 99;
        else begin
            for (int i = 0; i < n_exp; i++) begin
                if (bad < 0 && (log_op[i] != exp_op[i] || log_last[i] != exp_last[i] ||
                    (exp_op[i] == 1 && log_byte[i] != exp_byte[i]))) bad = i;
            end
        end
        if (bad == 99) chk(0, {tag, " op count"}, n_log, n_exp);
        else if (bad >= 0)
            chk(0, {tag, " op/byte at step"}, (log_op[bad] << 8) | log_byte[bad],
                (exp_op[bad] << 8) | exp_byte[bad]);
        else chk(1, tag, 0, 0);
        reg_read(0, v);
        chk(v == x_stat, {tag, " status"}, v, x_stat);
        if (x_err == 0 && x_rd != 0 && x_kind != 0) begin
            reg_read(5, v);
            chk(v == rx_vals[0], {tag, " data0"}, v, rx_vals[0]);
            if (x_kind == 3) begin
                reg_read(6, v);
                chk(v == rx_vals[1], {tag, " data1"}, v, rx_vals[1]);
            end
        end
        reg_write(0, 8'h1E);
        reg_read(0, v);
        chk(v == 0, "R11 status clear", v, 0);
    endtask

    function automatic string kind_tag(int k);
        case (k)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int v, nl, ofs[6];
        void'($urandom(32'd20240611));
        ofs = '{0, 2, 3, 4, 5, 6};
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            reg_read(ofs[i], v);
            chk(v == 0, "R1 reset value", v, 0);
        end
        chk(eng_req == 1'b0, "R1 no request", eng_req, 0);

        // Directed: every type in both directions.
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 2; r++) begin
                start_xact(k, r, $urandom_range(0, 127), $urandom_range(0, 255),
                           $urandom_range(0, 255), $urandom_range(0, 255), 0);
                finish_xact(kind_tag(k));
            end
        end

        // R7: NACK; R8: collision.
        start_xact(2, 0, 7'h2A, 8'h11, 8'h22, 8'h33, 1);
        finish_xact("R7 nack");
        start_xact(3, 0, 7'h15, 8'h44, 8'h55, 8'h66, 2);
        finish_xact("R8 lost");

        // R10: unsupported type code 5.
        n_log = 0;
        reg_write(2, 8'h40 | (5 << 2));
        repeat (6) @(negedge clk);
        reg_read(0, v);
        chk(v == 8'h10, "R10 failed on bad type", v, 8'h10);
        chk(n_log == 0, "R10 no bus activity", n_log, 0);

        // R2: start refused while failed is pending.
        reg_write(2, 8'h40);
        repeat (6) @(negedge clk);
        reg_read(0, v);
        chk(v == 8'h10, "R2 refused start keeps status", v, 8'h10);
        chk(n_log == 0, "R2 refused start no activity", n_log, 0);

        // R11: writing a zero or a different bit leaves failed set.
        reg_write(0, 8'h0F);
        reg_read(0, v);
        chk(v == 8'h10, "R11 unrelated bits kept", v, 8'h10);
        reg_write(0, 8'h10);
        reg_read(0, v);
        chk(v == 8'h00, "R11 failed cleared", v, 0);

        // R9: kill during a long operation.
        lat_cfg = 30;
        n_abort = 0;
        start_xact(3, 0, 7'h33, 8'h01, 8'h02, 8'h03, 0);
        repeat (4) @(negedge clk);
        reg_write(2, 8'h0E);
        repeat (2) @(negedge clk);
        chk(n_abort == 1, "R9 abort pulse count", n_abort, 1);
        reg_read(0, v);
        chk(v == 8'h10, "R9 failed and not busy", v, 8'h10);
        nl = n_log;
        repeat (40) @(negedge clk);
        chk(n_log == nl, "R9 no request after kill", n_log, nl);
        lat_cfg = 0;
        reg_write(2, 8'h00);
        reg_write(0, 8'h10);

        // R12: writes during busy are ignored.
        lat_cfg = 12;
        start_xact(2, 0, 7'h5A, 8'hC3, 8'h3C, 8'h00, 0);
        reg_write(4, 8'h55);
        reg_write(3, 8'h66);
        reg_write(5, 8'h77);
        lat_cfg = 0;
        finish_xact("R12 frozen bytes sent");
        reg_read(4, v);
        chk(v == x_areg, "R12 address unchanged", v, x_areg);
        reg_read(5, v);
        chk(v == x_d0, "R12 data0 unchanged", v, x_d0);

        // Random mix.
        for (int it = 0; it < 40; it++) begin
            int k, r, e, sel;
            k = $urandom_range(0, 3);
            r = $urandom_range(0, 1);
            sel = $urandom_range(0, 9);
            e = (sel == 0) ? 1 : (sel == 1) ? 2 : 0;
            start_xact(k, r, $urandom_range(0, 127), $urandom_range(0, 255),
                       $urandom_range(0, 255), $urandom_range(0, 255), e);
            finish_xact(e == 1 ? "R7" : e == 2 ? "R8" : kind_tag(k));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule